// File: doc/BRIEF.md
# Rectangular Window Line-Address Sequencer

This block takes the fields of one image-transfer job and turns them into a series of line requests. Each request carries a memory address and a byte count. A job describes a rectangular window inside a frame buffer: a buffer start address, a pixel depth in bits, a left offset and width in pixels, a line count, a data-type code, a flag for each line parity that suppresses those lines, a flag that selects a single flat transfer, and a flag that marks the job as outbound, meaning from the client to memory.

A job is accepted with a one-cycle `start_i` pulse while the block is idle. Requests leave on a valid/ready handshake. The job's line pitch and its first address both come from the pixel depth. A 4:2:0 chroma plane is handled as 8-bit data with half as many lines. When every request of the job has been accepted, the block pulses `done_o` for one cycle. Fetching memory and formatting pixels are left to the blocks around this one.

Top module: `win_dma_agen`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `req_valid_o` and `done_o` are low until a job is started.
- R2: In line mode the line pitch in bytes is floor(depth × width / 8). Every line request carries this value as its byte count.
- R3: The first line address is the base address plus floor(left × depth / 8).
- R4: Line k, counting from 0, has the address first + k × pitch. A job without line skipping emits exactly `height_i` requests.
- R5: When `dtype_i` equals the chroma 4:2:0 code (4'd5 by default), the depth is taken as 8 whatever `depth_i` holds, and the line count becomes floor(height / 2).
- R6: `skip_even_i` suppresses lines with an even index (0, 2, …) and `skip_odd_i` suppresses lines with an odd index. Each suppressed line still moves the address on by one pitch and takes one cycle with `req_valid_o` low.
- R7: With `flat_i` set and a non-zero height, the job emits one request at the first address with floor(depth × width × height / 8) bytes. The skip flags have no effect in this mode.
- R8: While `req_valid_o` is high and `req_ready_i` is low, the request stays valid and its address and byte count stay stable.
- R9: `done_o` is high for exactly one cycle. That cycle follows the cycle in which the last line left, either accepted or skipped. A job with zero lines raises `done_o` in the cycle after its start and emits no request.
- R10: A `start_i` pulse while `busy_o` is high is ignored, and the running job's requests are unchanged.
- R11: For outbound jobs the width is limited to 1920 pixels and the line count to 1080, before any 4:2:0 halving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a job from the field inputs when idle |
| base_addr_i | input | 32 | Frame buffer start address |
| depth_i | input | 6 | Bits per pixel (4, 8, 16, 24, 32) |
| left_i | input | 12 | Window left offset in pixels |
| width_i | input | 12 | Window width in pixels |
| height_i | input | 12 | Number of lines |
| dtype_i | input | 4 | Data-type code (4:2:0 chroma is 4'd5) |
| outbound_i | input | 1 | Job writes memory; applies the size limit |
| skip_even_i | input | 1 | Suppress even-index lines |
| skip_odd_i | input | 1 | Suppress odd-index lines |
| flat_i | input | 1 | One flat request for the whole window |
| busy_o | output | 1 | Job in progress |
| req_valid_o | output | 1 | Line request valid |
| req_ready_i | input | 1 | Line request accepted |
| req_addr_o | output | 32 | Line start address |
| req_bytes_o | output | 32 | Line byte count |
| done_o | output | 1 | One-cycle job-complete pulse |

## Verification
Completion of one job and acceptance of the next can happen in the same cycle. `done_o` is high in the first idle cycle, so a `start_i` driven in that cycle is accepted at once. The bench provokes this by starting a second job exactly on the cycle of the first job's done pulse. It then checks that the done pulse was seen and that the new job's first request comes out at its own first address in the very next cycle. A separate case drives a start in the middle of a job and confirms that the running job's address series is not disturbed.

// File: rtl/win_dma_pkg.sv
package win_dma_pkg;

    // data-type code that marks a 4:2:0 chroma plane
    localparam logic [3:0] CODE_CHROMA420 = 4'd5;

    // fixed pixel depth used for 4:2:0 chroma planes
    localparam int unsigned CHROMA420_BITS = 8;

endpackage

// File: rtl/win_geom.sv
module win_geom
    import win_dma_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DEPTH_W = 6,
    parameter int unsigned DIM_W   = 12,
    parameter int unsigned TYPE_W  = 4,
    parameter int unsigned MAX_W   = 1920,
    parameter int unsigned MAX_H   = 1080,
    parameter logic [TYPE_W-1:0] C420_CODE = TYPE_W'(CODE_CHROMA420)
) (
    input  logic [ADDR_W-1:0]  base_addr_i,
    input  logic [DEPTH_W-1:0] depth_i,
    input  logic [DIM_W-1:0]   left_i,
    input  logic [DIM_W-1:0]   width_i,
    input  logic [DIM_W-1:0]   height_i,
    input  logic [TYPE_W-1:0]  dtype_i,
    input  logic               outbound_i,
    input  logic               flat_i,
    output logic [ADDR_W-1:0]  first_o,
    output logic [ADDR_W-1:0]  pitch_o,
    output logic [ADDR_W-1:0]  bytes_o,
    output logic [DIM_W-1:0]   lines_o
);
    localparam logic [DIM_W-1:0]   LIM_W = DIM_W'(MAX_W);
    localparam logic [DIM_W-1:0]   LIM_H = DIM_W'(MAX_H);
    localparam logic [DEPTH_W-1:0] DEP420 = DEPTH_W'(CHROMA420_BITS);

    logic [DEPTH_W-1:0] dep;
    logic [DIM_W-1:0]   w_eff;
    logic [DIM_W-1:0]   h_eff;
    logic [ADDR_W-1:0]  row_bits;
    logic [ADDR_W-1:0]  all_bits;

    always_comb begin
        dep   = (dtype_i == C420_CODE) ? DEP420 : depth_i;
        w_eff = width_i;
        h_eff = height_i;
        if (outbound_i) begin
            if (w_eff > LIM_W) w_eff = LIM_W;
            if (h_eff > LIM_H) h_eff = LIM_H;
        end
        if (dtype_i == C420_CODE) h_eff = h_eff >> 1;

        row_bits = ADDR_W'(dep) * ADDR_W'(w_eff);
        all_bits = row_bits * ADDR_W'(h_eff);
        first_o  = base_addr_i + ((ADDR_W'(dep) * ADDR_W'(left_i)) >> 3);
        pitch_o  = row_bits >> 3;

        if (flat_i) begin
            bytes_o = all_bits >> 3;
            lines_o = (h_eff != '0) ? DIM_W'(1) : '0;
        end else begin
            bytes_o = row_bits >> 3;
            lines_o = h_eff;
        end
    end
endmodule

// File: rtl/win_line_walker.sv
module win_line_walker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DIM_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] first_i,
    input  logic [ADDR_W-1:0] pitch_i,
    input  logic [ADDR_W-1:0] bytes_i,
    input  logic [DIM_W-1:0]  lines_i,
    input  logic              skip_even_i,
    input  logic              skip_odd_i,
    input  logic              flat_i,
    input  logic              req_ready_i,
    output logic              req_valid_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [ADDR_W-1:0] req_bytes_o,
    output logic              busy_o,
    output logic              done_o
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] pitch;
        logic [ADDR_W-1:0] bytes;
        logic [DIM_W-1:0]  idx;
        logic [DIM_W-1:0]  lines;
        logic              skip_e;
        logic              skip_o;
    } walk_t;

    walk_t walk_d, walk_q;
    logic  skip_now;
    logic  last_line;

    always_comb begin
        walk_d    = walk_q;
        walk_d.done = 1'b0;
        skip_now  = walk_q.idx[0] ? walk_q.skip_o : walk_q.skip_e;
        last_line = (walk_q.idx + DIM_W'(1)) == walk_q.lines;
        req_valid_o = walk_q.busy && !skip_now;

        if (!walk_q.busy) begin
            if (start_i) begin
                if (lines_i == '0) begin
                    walk_d.done = 1'b1;
                end else begin
                    walk_d.busy   = 1'b1;
                    walk_d.addr   = first_i;
                    walk_d.pitch  = pitch_i;
                    walk_d.bytes  = bytes_i;
                    walk_d.idx    = '0;
                    walk_d.lines  = lines_i;
                    walk_d.skip_e = skip_even_i && !flat_i;
                    walk_d.skip_o = skip_odd_i && !flat_i;
                end
            end
        end else if (skip_now || req_ready_i) begin
            if (last_line) begin
                walk_d.busy = 1'b0;
                walk_d.done = 1'b1;
            end else begin
                walk_d.idx  = walk_q.idx + DIM_W'(1);
                walk_d.addr = walk_q.addr + walk_q.pitch;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign req_addr_o  = walk_q.addr;
    assign req_bytes_o = walk_q.bytes;
    assign busy_o      = walk_q.busy;
    assign done_o      = walk_q.done;

    // R8: a stalled request keeps its contents
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_bytes_o));

    // R9: completion pulse only while idle and quiet
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !req_valid_o);

    // R9: accepting the final request ends the job next cycle
    p_last_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && req_ready_i && last_line |=> !busy_o && done_o);

    // R9: done never lasts two cycles
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o || $past(start_i));
endmodule

// File: rtl/win_dma_agen.sv
module win_dma_agen
    import win_dma_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DEPTH_W = 6,
    parameter int unsigned DIM_W   = 12,
    parameter int unsigned TYPE_W  = 4,
    parameter int unsigned MAX_W   = 1920,
    parameter int unsigned MAX_H   = 1080
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [ADDR_W-1:0]  base_addr_i,
    input  logic [DEPTH_W-1:0] depth_i,
    input  logic [DIM_W-1:0]   left_i,
    input  logic [DIM_W-1:0]   width_i,
    input  logic [DIM_W-1:0]   height_i,
    input  logic [TYPE_W-1:0]  dtype_i,
    input  logic               outbound_i,
    input  logic               skip_even_i,
    input  logic               skip_odd_i,
    input  logic               flat_i,
    output logic               busy_o,
    output logic               req_valid_o,
    input  logic               req_ready_i,
    output logic [ADDR_W-1:0]  req_addr_o,
    output logic [ADDR_W-1:0]  req_bytes_o,
    output logic               done_o
);
    logic [ADDR_W-1:0] first_w;
    logic [ADDR_W-1:0] pitch_w;
    logic [ADDR_W-1:0] bytes_w;
    logic [DIM_W-1:0]  lines_w;

    win_geom #(
        .ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W), .DIM_W(DIM_W), .TYPE_W(TYPE_W),
        .MAX_W(MAX_W), .MAX_H(MAX_H), .C420_CODE(TYPE_W'(CODE_CHROMA420))
    ) i_geom (
        .base_addr_i (base_addr_i),
        .depth_i     (depth_i),
        .left_i      (left_i),
        .width_i     (width_i),
        .height_i    (height_i),
        .dtype_i     (dtype_i),
        .outbound_i  (outbound_i),
        .flat_i      (flat_i),
        .first_o     (first_w),
        .pitch_o     (pitch_w),
        .bytes_o     (bytes_w),
        .lines_o     (lines_w)
    );

    win_line_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) i_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .first_i     (first_w),
        .pitch_i     (pitch_w),
        .bytes_i     (bytes_w),
        .lines_i     (lines_w),
        .skip_even_i (skip_even_i),
        .skip_odd_i  (skip_odd_i),
        .flat_i      (flat_i),
        .req_ready_i (req_ready_i),
        .req_valid_o (req_valid_o),
        .req_addr_o  (req_addr_o),
        .req_bytes_o (req_bytes_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    // R11: outbound jobs never exceed the line limit
    p_line_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        outbound_i |-> lines_w <= DIM_W'(MAX_H));

    // R3: a new job begins at the computed first address
    p_first_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> req_addr_o == $past(first_w));
endmodule

// File: tb/test_win_dma_agen.sv
`timescale 1ns/1ps
module test_win_dma_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic [5:0]  depth_i = '0;
    logic [11:0] left_i = '0, width_i = '0, height_i = '0;
    logic [3:0]  dtype_i = '0;
    logic        outbound_i = 1'b0, skip_even_i = 1'b0, skip_odd_i = 1'b0, flat_i = 1'b0;
    logic        req_ready_i = 1'b0;
    logic        busy_o, req_valid_o, done_o;
    logic [31:0] req_addr_o, req_bytes_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    win_dma_agen i_win_dma_agen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
        .depth_i(depth_i), .left_i(left_i), .width_i(width_i), .height_i(height_i),
        .dtype_i(dtype_i), .outbound_i(outbound_i), .skip_even_i(skip_even_i),
        .skip_odd_i(skip_odd_i), .flat_i(flat_i), .busy_o(busy_o),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
        .req_bytes_o(req_bytes_o), .done_o(done_o)
    );

    typedef struct packed {
        logic [31:0] base;
        logic [5:0]  depth;
        logic [11:0] left;
        logic [11:0] width;
        logic [11:0] height;
        logic [3:0]  dtype;
        logic        outb;
        logic        se;
        logic        so;
        logic        fl;
        logic [31:0] efirst;
        logic [31:0] epitch;
        logic [11:0] elines;
        logic [31:0] ebytes;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R2 R3 R4: 8-bit
        '{32'h1000, 6'd8, 12'd4, 12'd16, 12'd3, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1004, 32'd16, 12'd3, 32'd16},
        // R2 R3 R4: 16-bit
        '{32'h2000, 6'd16, 12'd10, 12'd20, 12'd4, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2014, 32'd40, 12'd4, 32'd40},
        // R2 R3: 24-bit
        '{32'h3000, 6'd24, 12'd3, 12'd5, 12'd2, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h3009, 32'd15, 12'd2, 32'd15},
        // R2 R3: 4-bit, floors
        '{32'h4000, 6'd4, 12'd5, 12'd7, 12'd2, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h4002, 32'd3, 12'd2, 32'd3},
        // R2 R3: 32-bit
        '{32'h5000, 6'd32, 12'd1, 12'd3, 12'd2, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h5004, 32'd12, 12'd2, 32'd12},
        // R5: 4:2:0 chroma, depth forced 8, lines 5 -> 2
        '{32'h6000, 6'd4, 12'd6, 12'd10, 12'd5, 4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 32'h6006, 32'd10, 12'd2, 32'd10},
        // R6: skip even
        '{32'h7000, 6'd8, 12'd0, 12'd8, 12'd5, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h7000, 32'd8, 12'd5, 32'd8},
        // R6: skip odd
        '{32'h7800, 6'd8, 12'd2, 12'd8, 12'd4, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h7802, 32'd8, 12'd4, 32'd8},
        // R7: flat, skip flag ignored
        '{32'h8000, 6'd16, 12'd2, 12'd10, 12'd3, 4'd0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h8004, 32'd0, 12'd1, 32'd60},
        // R11: outbound clamp
        '{32'h0, 6'd8, 12'd0, 12'd2000, 12'd1100, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'd1920, 12'd1080, 32'd1920},
        // R6 R9: every line skipped
        '{32'h9000, 6'd8, 12'd0, 12'd4, 12'd3, 4'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h9000, 32'd4, 12'd3, 32'd4},
        // R9: zero lines
        '{32'hA000, 6'd8, 12'd0, 12'd4, 12'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hA000, 32'd4, 12'd0, 32'd4}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        base_addr_i = v.base; depth_i = v.depth; left_i = v.left; width_i = v.width;
        height_i = v.height; dtype_i = v.dtype; outbound_i = v.outb;
        skip_even_i = v.se; skip_odd_i = v.so; flat_i = v.fl;
    endtask

    // called at the negedge after the start edge; ends at the done negedge
    task automatic walk(input vec_t v, input string tag);
        for (int i = 0; i < int'(v.elines); i++) begin
            bit skip;
            logic [31:0] ea;
            skip = !v.fl && ((i % 2 == 1) ? v.so : v.se);
            ea = v.efirst + 32'(i) * v.epitch;
            if (skip)
                check(!req_valid_o, {tag, " R6 skipped line valid"}, 32'(req_valid_o), 32'd0);
            else
                check(req_valid_o && req_addr_o == ea && req_bytes_o == v.ebytes,
                      {tag, " R2/R4 line addr"}, req_addr_o, ea);
            @(negedge clk);
        end
        check(done_o && !busy_o, {tag, " R9 done pulse"}, 32'(done_o), 32'd1);
    endtask

    task automatic run(input vec_t v, input string tag);
        @(negedge clk);
        drive(v); start_i = 1'b1; req_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        walk(v, tag);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy_o && !req_valid_o && !done_o, "R1 in reset", {29'd0, busy_o, req_valid_o, done_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !req_valid_o && !done_o, "R1 after reset", {29'd0, busy_o, req_valid_o, done_o}, 32'd0);

        for (int k = 0; k < NV; k++) begin
            run(VECS[k], $sformatf("vec%0d", k));
            @(negedge clk);
            check(!done_o, "R9 done one cycle", 32'(done_o), 32'd0);
        end

        // R8: backpressure holds the first request
        @(negedge clk);
        drive(VECS[0]); start_i = 1'b1; req_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int s = 0; s < 3; s++) begin
            check(req_valid_o && req_addr_o == 32'h1004 && req_bytes_o == 32'd16, "R8 stall hold", req_addr_o, 32'h1004);
            @(negedge clk);
        end
        req_ready_i = 1'b1;
        walk(VECS[0], "R8 resume");

        // R9 coincidence: next job started in the done cycle
        drive(VECS[3]); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && req_addr_o == 32'h4002, "R9 start on done cycle", req_addr_o, 32'h4002);
        walk(VECS[3], "R9 back-to-back");

        // R10: start while busy is ignored
        @(negedge clk);
        drive(VECS[1]); start_i = 1'b1; req_ready_i = 1'b1;
        @(negedge clk);
        drive(VECS[2]); start_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            check(req_valid_o && req_addr_o == 32'h2014 + 32'(i) * 32'd40 && req_bytes_o == 32'd40,
                  "R10 running job kept", req_addr_o, 32'h2014 + 32'(i) * 32'd40);
            if (i == 1) start_i = 1'b0;
            @(negedge clk);
        end
        check(done_o, "R10 done of first job", 32'(done_o), 32'd1);
        @(negedge clk);
        check(!busy_o && !req_valid_o, "R10 second start not taken", 32'(busy_o), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule